// File: doc/BRIEF.md
# Accumulator–Memory Digit Rotate Unit

This unit runs the two packed-decimal digit rotations that move 4-bit digits through a chain of three nibbles. Two of the nibbles are the high and low halves of a memory byte. The third is the low half of an 8-bit accumulator. The caller raises a one-cycle start strobe and supplies a direction, the current accumulator, the current flag byte and a 16-bit pointer. The unit reads the byte at the pointer and recombines the nibbles in a separate cycle. It then writes the new byte back to the same address and returns the new accumulator and flag byte.

The memory side is a single request/ready port. A transfer is accepted in a cycle where both request and ready are high. In the right rotation, the accumulator digit enters the high end of the memory byte and the low memory digit moves into the accumulator. The left rotation runs the chain the other way. The accumulator high digit is never changed. The carry bit passes through unchanged, and sign, zero and parity are taken from the new accumulator.

Top module: `nib_rot_unit`

## Requirements
- R1: After reset, mem_req_o, done_o and busy_o are low and acc_o and flags_o are zero.
- R2: For a right rotation (rot_left_i = 0), the byte written is {acc[3:0], mem[7:4]}, with the old accumulator low digit in bits 7:4 and the old memory high digit in bits 3:0.
- R3: For a right rotation, the new accumulator is {acc[7:4], mem[3:0]}.
- R4: For a left rotation (rot_left_i = 1), the byte written is {mem[3:0], acc[3:0]}.
- R5: For a left rotation, the new accumulator is {acc[7:4], mem[7:4]}.
- R6: The flag byte returned has bit 7 = bit 7 of the new accumulator, bit 6 = 1 when the new accumulator is zero, bit 2 = 1 when the new accumulator has an even number of one bits, and bit 0 = bit 0 of the flag byte given at start. Bits 5, 4, 3 and 1 are zero.
- R7: Each operation makes exactly one read and then one write, both at the pointer value captured with the accepted start.
- R8: Once mem_req_o is raised, it stays high with mem_we_o, mem_addr_o and mem_wdata_o unchanged until mem_ready_i is seen high.
- R9: done_o is high for exactly one cycle, the cycle after the write is accepted. acc_o and flags_o take their new values in that cycle and hold them at all other times.
- R10: A start strobe that arrives while busy_o is high does not launch a second operation.
- R11: The direction, accumulator, flag and pointer inputs are captured with the accepted start, and later changes to them do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| rot_left_i | input | 1 | 1 selects the left rotation, 0 the right |
| acc_i | input | 8 | Accumulator value at start |
| flags_i | input | 8 | Flag byte at start (bit 0 is carry) |
| ptr_i | input | 16 | Address of the memory byte |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 for the write, 0 for the read |
| mem_addr_o | output | 16 | Transfer address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with mem_ready_i on a read |
| mem_ready_i | input | 1 | Memory accepts or completes the transfer |
| acc_o | output | 8 | New accumulator |
| flags_o | output | 8 | New flag byte |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory raises mem_ready_i only in reply to a request. They also assume that read data is valid in the cycle ready is high and that ready eventually arrives. The bench model of the memory never asserts ready without a request and drops it in the cycle after each accepted transfer. It inserts a fixed number of wait cycles, chosen per scenario, before each reply. Start is pulsed only at negative edges, and the intrusive start pulses and input changes are placed inside the busy window.

// File: rtl/nib_rot_pkg.sv
package nib_rot_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  // flag byte bit positions (decoded by the surrounding core)
  localparam int FLG_S = 7;
  localparam int FLG_Z = 6;
  localparam int FLG_H = 4;
  localparam int FLG_P = 2;
  localparam int FLG_N = 1;
  localparam int FLG_C = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MERGE,
    ST_WRITE,
    ST_FINISH
  } seq_state_t;

  typedef enum logic {
    ROT_RIGHT = 1'b0,
    ROT_LEFT  = 1'b1
  } rot_dir_t;

  typedef struct packed {
    logic [BYTE_W-1:0] mem;
    logic [BYTE_W-1:0] acc;
  } rot_pair_t;

  // moves one digit along the accumulator-low / memory-high / memory-low chain
  function automatic rot_pair_t rotate_digits(rot_dir_t dir,
                                              logic [BYTE_W-1:0] m,
                                              logic [BYTE_W-1:0] a);
    rot_pair_t r;
    if (dir == ROT_LEFT) begin
      r.mem = {m[NIB_W-1:0], a[NIB_W-1:0]};
      r.acc = {a[BYTE_W-1:NIB_W], m[BYTE_W-1:NIB_W]};
    end else begin
      r.mem = {a[NIB_W-1:0], m[BYTE_W-1:NIB_W]};
      r.acc = {a[BYTE_W-1:NIB_W], m[NIB_W-1:0]};
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] digit_flags(logic [BYTE_W-1:0] acc,
                                                    logic [BYTE_W-1:0] old);
    logic [BYTE_W-1:0] f;
    f        = '0;
    f[FLG_S] = acc[BYTE_W-1];
    f[FLG_Z] = (acc == '0);
    f[FLG_H] = 1'b0;
    f[FLG_P] = ~^acc;
    f[FLG_N] = 1'b0;
    f[FLG_C] = old[FLG_C];
    return f;
  endfunction

endpackage

// File: rtl/nib_rot_seq.sv
module nib_rot_seq
  import nib_rot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mem_ready_i,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic busy_o,
  output logic done_o,
  output logic ev_accept_o,
  output logic ev_rd_ack_o,
  output logic ev_merge_o,
  output logic ev_wr_ack_o
);

  seq_state_t state_q, state_d;

  assign ev_accept_o = (state_q == ST_IDLE)  && start_i;
  assign ev_rd_ack_o = (state_q == ST_READ)  && mem_ready_i;
  assign ev_merge_o  = (state_q == ST_MERGE);
  assign ev_wr_ack_o = (state_q == ST_WRITE) && mem_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i)     state_d = ST_READ;
      ST_READ:   if (mem_ready_i) state_d = ST_MERGE;
      ST_MERGE:                   state_d = ST_WRITE;
      ST_WRITE:  if (mem_ready_i) state_d = ST_FINISH;
      ST_FINISH:                  state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign mem_req_o = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o  = (state_q == ST_WRITE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FINISH);

endmodule

// File: rtl/nib_rot_dp.sv
module nib_rot_dp
  import nib_rot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept_i,
  input  logic              ev_rd_ack_i,
  input  logic              ev_merge_i,
  input  logic              ev_wr_ack_i,
  input  logic              rot_left_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] flags_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [BYTE_W-1:0] acc_o,
  output logic [BYTE_W-1:0] flags_o
);

  rot_dir_t          dir_q;
  logic [BYTE_W-1:0] acc_q, flg_q, rd_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] res_byte_q, res_acc_q, res_flg_q;
  logic [BYTE_W-1:0] acc_out_q, flg_out_q;
  rot_pair_t         pair;

  assign pair = rotate_digits(dir_q, rd_q, acc_q);

  // operands captured with the accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= ROT_RIGHT;
      acc_q <= '0;
      flg_q <= '0;
      ptr_q <= '0;
    end else if (ev_accept_i) begin
      dir_q <= rot_dir_t'(rot_left_i);
      acc_q <= acc_i;
      flg_q <= flags_i;
      ptr_q <= ptr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_q <= '0;
    else if (ev_rd_ack_i) rd_q <= mem_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_byte_q <= '0;
      res_acc_q  <= '0;
      res_flg_q  <= '0;
    end else if (ev_merge_i) begin
      res_byte_q <= pair.mem;
      res_acc_q  <= pair.acc;
      res_flg_q  <= digit_flags(pair.acc, flg_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out_q <= '0;
      flg_out_q <= '0;
    end else if (ev_wr_ack_i) begin
      acc_out_q <= res_acc_q;
      flg_out_q <= res_flg_q;
    end
  end

  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = res_byte_q;
  assign acc_o       = acc_out_q;
  assign flags_o     = flg_out_q;

endmodule

// File: rtl/nib_rot_unit.sv
module nib_rot_unit
  import nib_rot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rot_left_i,
  input  logic [7:0]        acc_i,
  input  logic [7:0]        flags_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [7:0]        acc_o,
  output logic [7:0]        flags_o,
  output logic              busy_o,
  output logic              done_o
);

  logic ev_accept, ev_rd_ack, ev_merge, ev_wr_ack;

  nib_rot_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_ready_i (mem_ready_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ev_accept_o (ev_accept),
    .ev_rd_ack_o (ev_rd_ack),
    .ev_merge_o  (ev_merge),
    .ev_wr_ack_o (ev_wr_ack)
  );

  nib_rot_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_accept_i (ev_accept),
    .ev_rd_ack_i (ev_rd_ack),
    .ev_merge_i  (ev_merge),
    .ev_wr_ack_i (ev_wr_ack),
    .rot_left_i  (rot_left_i),
    .acc_i       (acc_i),
    .flags_i     (flags_i),
    .ptr_i       (ptr_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .acc_o       (acc_o),
    .flags_o     (flags_o)
  );

endmodule

// File: rtl/nib_rot_chk.sv
module nib_rot_chk
  import nib_rot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o,
  input logic              mem_ready_i,
  input logic [7:0]        acc_o,
  input logic [7:0]        flags_o,
  input logic              done_o,
  input logic              ev_rd_ack,
  input logic              ev_wr_ack
);

  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_addr_q <= '0;
    else if (ev_rd_ack) rd_addr_q <= mem_addr_o;
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                     $stable(mem_addr_o) && $stable(mem_wdata_o)));

  p_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == rd_addr_q));

  p_read_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_ack |=> !mem_req_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ev_wr_ack));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(acc_o) && $stable(flags_o)));

  p_flag_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flags_o[FLG_H] == 1'b0 && flags_o[FLG_N] == 1'b0 &&
                flags_o[5] == 1'b0 && flags_o[3] == 1'b0 &&
                flags_o[FLG_Z] == (acc_o == 8'h00) &&
                flags_o[FLG_S] == acc_o[7] &&
                flags_o[FLG_P] == ~^acc_o));

endmodule

bind nib_rot_unit nib_rot_chk #(.ADDR_W(ADDR_W)) i_nib_rot_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .acc_o       (acc_o),
  .flags_o     (flags_o),
  .done_o      (done_o),
  .ev_rd_ack   (ev_rd_ack),
  .ev_wr_ack   (ev_wr_ack)
);

// File: tb/test_nib_rot_unit.sv
`timescale 1ns/1ps
module test_nib_rot_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rot_left_i = 1'b0;
  logic [7:0]  acc_i = '0;
  logic [7:0]  flags_i = '0;
  logic [15:0] ptr_i = '0;
  logic        mem_req_o, mem_we_o, busy_o, done_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, acc_o, flags_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  // memory model controls (driven by the scenario tasks only)
  logic [7:0] rd_val = '0;
  int         wait_n = 0;
  // memory model records (driven by the model only)
  int          rd_cnt = 0, wr_cnt = 0, order_err = 0, hold_err = 0;
  logic [15:0] last_raddr = '0, last_waddr = '0;
  logic [7:0]  last_wdata = '0;

  always #5 clk = ~clk;

  nib_rot_unit i_nib_rot_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rot_left_i(rot_left_i),
    .acc_i(acc_i), .flags_i(flags_i), .ptr_i(ptr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .acc_o(acc_o), .flags_o(flags_o), .busy_o(busy_o), .done_o(done_o)
  );

  // ready driver: replies after wait_n idle request cycles, drops after acceptance
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready_i) begin
        mem_ready_i = 1'b0;
        cnt = 0;
      end else if (mem_req_o) begin
        if (cnt >= wait_n) begin
          mem_ready_i = 1'b1;
          mem_rdata_i = rd_val;
        end else begin
          cnt++;
        end
      end
    end
  end

  // transfer recorder at the accepting edge
  initial begin
    logic        p_req, p_rdy, p_we;
    logic [15:0] p_addr;
    logic [7:0]  p_wd;
    p_req = 1'b0; p_rdy = 1'b0; p_we = 1'b0; p_addr = '0; p_wd = '0;
    forever begin
      @(posedge clk);
      if (rst_n && p_req && !p_rdy &&
          (!mem_req_o || mem_we_o != p_we || mem_addr_o != p_addr || mem_wdata_o != p_wd))
        hold_err++;
      if (rst_n && mem_req_o && mem_ready_i) begin
        if (mem_we_o) begin
          if (rd_cnt == wr_cnt) order_err++;
          wr_cnt++;
          last_waddr = mem_addr_o;
          last_wdata = mem_wdata_o;
        end else begin
          rd_cnt++;
          last_raddr = mem_addr_o;
        end
      end
      p_req = mem_req_o; p_rdy = mem_ready_i; p_we = mem_we_o;
      p_addr = mem_addr_o; p_wd = mem_wdata_o;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_flags(logic [7:0] a, logic [7:0] f_in);
    int ones;
    logic [7:0] f;
    ones = 0;
    for (int i = 0; i < 8; i++) if (a[i]) ones++;
    f = 8'h00;
    if (a >= 8'h80)    f = f | 8'h80;
    if (a == 8'h00)    f = f | 8'h40;
    if (ones % 2 == 0) f = f | 8'h04;
    f = f | (f_in & 8'h01);
    return f;
  endfunction

  task automatic do_op(bit left, logic [7:0] a, logic [7:0] f, logic [15:0] p,
                       logic [7:0] m, int waits, bit disturb);
    int r0, w0;
    bit seen;
    logic [7:0] e_mem, e_acc, e_flg;
    string rm, ra;
    if (left) begin
      e_mem = {m[3:0], a[3:0]};
      e_acc = (a & 8'hF0) | (m >> 4);
      rm = "R4"; ra = "R5";
    end else begin
      e_mem = ((a << 4) | (m >> 4)) & 8'hFF;
      e_acc = (a & 8'hF0) | (m & 8'h0F);
      rm = "R2"; ra = "R3";
    end
    e_flg = ref_flags(e_acc, f);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    rd_val = m; wait_n = waits;
    rot_left_i = left; acc_i = a; flags_i = f; ptr_i = p; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      // R10 R11: fresh start and new operands while the first op runs
      rot_left_i = ~left; acc_i = ~a; flags_i = ~f; ptr_i = ~p; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    seen = 1'b0;
    for (int n = 0; n < 200 && !seen; n++) begin
      if (done_o) seen = 1'b1;
      else @(negedge clk);
    end
    check("R9", "done seen", 32'(seen), 32'd1);
    check(ra, "accumulator", 32'(acc_o), 32'(e_acc));
    check("R6", "flags", 32'(flags_o), 32'(e_flg));
    check(rm, "written byte", 32'(last_wdata), 32'(e_mem));
    check("R7", "read address", 32'(last_raddr), 32'(p));
    check("R7", "write address", 32'(last_waddr), 32'(p));
    check("R7", "read before write", 32'(order_err), 32'd0);
    @(negedge clk);
    check("R9", "done one cycle", 32'(done_o), 32'd0);
    check("R9", "accumulator held", 32'(acc_o), 32'(e_acc));
    check("R10", "idle after op", 32'(busy_o), 32'd0);
    check("R7", "one read", 32'(rd_cnt - r0), 32'd1);
    check("R7", "one write", 32'(wr_cnt - w0), 32'd1);
  endtask

  task automatic t_reset;
    check("R1", "req", 32'(mem_req_o), 32'd0);
    check("R1", "done", 32'(done_o), 32'd0);
    check("R1", "busy", 32'(busy_o), 32'd0);
    check("R1", "acc", 32'(acc_o), 32'd0);
    check("R1", "flags", 32'(flags_o), 32'd0);
  endtask

  task automatic t_right_basic;   // R2 R3
    do_op(1'b0, 8'h5A, 8'h00, 16'h1234, 8'h3C, 0, 1'b0);
  endtask

  task automatic t_left_basic;    // R4 R5
    do_op(1'b1, 8'hC7, 8'hFF, 16'hBEEF, 8'h9E, 1, 1'b0);
  endtask

  task automatic t_zero_flag;     // R6: zero, even parity, carry kept
    do_op(1'b1, 8'h0F, 8'hFF, 16'h0001, 8'h0B, 0, 1'b0);
    check("R6", "zero case flags", 32'(flags_o), 32'h45);
  endtask

  task automatic t_sign_flag;     // R6: sign, odd parity, carry clear
    do_op(1'b0, 8'h93, 8'h00, 16'hFFFF, 8'h27, 2, 1'b0);
    check("R6", "sign case flags", 32'(flags_o), 32'h80);
  endtask

  task automatic t_wait_states;   // R8
    do_op(1'b0, 8'hE1, 8'h01, 16'h8000, 8'hF0, 4, 1'b0);
    do_op(1'b1, 8'h24, 8'h00, 16'h7FFE, 8'h6D, 3, 1'b0);
    check("R8", "request held until ready", 32'(hold_err), 32'd0);
  endtask

  task automatic t_start_ignored; // R10 R11
    do_op(1'b0, 8'h36, 8'h01, 16'h4321, 8'hA5, 2, 1'b1);
    do_op(1'b1, 8'h70, 8'h00, 16'h0F0F, 8'h18, 3, 1'b1);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_right_basic();
    t_left_basic();
    t_zero_flag();
    t_sign_flag();
    t_wait_states();
    t_start_ignored();
    summary();
    $finish;
  end

endmodule